// File: doc/BRIEF.md
# Auto-Reload PWM Timer

This block generates a pulse-width-modulated waveform from a free-running up-counter. The counter climbs to its all-ones value, flags an overflow, and reloads from a programmable start value. A toggle flop flips on that overflow and again when the counter passes a programmable compare value. The load value therefore sets the period, and the distance from load to compare sets the active time. A polarity bit inverts the output. An optional power-of-two prescaler slows the counting rate.

Software programs the block through a single-cycle write port. Four registers are addressed: a control word, the reload value, the compare value and the counter itself. Configuration can only change while the timer is halted. The usual sequence is to stop the timer, write load and compare, preset the counter two counts below wrap, and start it again. With that preset, the very first counter event already produces an edge.

Top module: `tpwm_timer`

## Requirements
- R1: After reset every register is zero, the counter is halted and `pwm_out` is low.
- R2: On a counting tick with the counter at all-ones, the counter reloads the LOAD register (address 1) if the auto-reload bit (control bit 1) is set, and wraps to zero if it is clear.
- R3: In toggle mode 2 (control bits 9:8 = 2 or 3) with compare enabled and no prescaling, one output period lasts (all-ones − load + 1) clocks.
- R4: In that mode the output is high for (match − load + 1) ticks and low for (all-ones − match) ticks, where match is the MATCH register (address 2).
- R5: With the counter (address 3) preset to all-ones minus one and the timer started, `pwm_out` rises on the second tick after the start write.
- R6: Control bit 7 inverts the output, so the default level becomes high and the high time becomes the inactive phase.
- R7: With control bit 3 set, the counter advances once every 2^(ps+1) clocks, where ps is control bits 6:4. With bit 3 clear, it advances on every clock while running.
- R8: While running (control bit 0 = 1), writes to LOAD, MATCH or COUNT are ignored, and a control write changes only the run bit.
- R9: Compare events toggle the output only when control bit 2 is set and the mode is 2 or 3. Mode 1 toggles on overflow only, and mode 0 never toggles.
- R10: An overflow and a compare match on the same tick produce a single toggle.
- R11: While halted and not written, `pwm_out` holds its level.
- R12: While halted, a COUNT write, or a control write that changes the mode field, returns the output to its default level (the polarity bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 load, 2 match, 3 count |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 1 | PWM waveform |

## Verification
When the compare value equals all-ones, the overflow and the compare match land on the same tick. The bench provokes this by programming match to all-ones with a ten-tick period. The check is passed if the output toggles once per period: a square wave of ten clocks high and ten low, rather than an output that stays flat because of a double toggle. The overflow-flip assertion also checks every such tick directly.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
   typedef enum logic [1:0] {
      A_CTRL  = 2'd0,
      A_LOAD  = 2'd1,
      A_MATCH = 2'd2,
      A_COUNT = 2'd3
   } tpwm_addr_e;

   typedef enum logic [1:0] {
      M_OFF  = 2'd0,
      M_OVF  = 2'd1,
      M_BOTH = 2'd2,
      M_ALT  = 2'd3
   } tpwm_mode_e;

   localparam int unsigned RUN_B  = 0;
   localparam int unsigned ARL_B  = 1;
   localparam int unsigned CMP_B  = 2;
   localparam int unsigned PSEN_B = 3;
   localparam int unsigned PS_LSB = 4;
endpackage

// File: rtl/tpwm_prescaler.sv
module tpwm_prescaler #(
   parameter int unsigned PS_W   = 3,
   parameter bit          HAS_PS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            ps_en,
   input  logic [PS_W-1:0] ps,
   output logic            tick
);
   localparam int unsigned DIV_W = 2 ** PS_W;

   generate
      if (HAS_PS) begin : g_div
         logic [DIV_W-1:0] div_q;
         logic [DIV_W:0]   span;
         logic             last;

         always_comb begin
            span = (DIV_W+1)'(1) << (int'(ps) + 1);
            last = (div_q == DIV_W'(span - (DIV_W+1)'(1)));
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      div_q <= '0;
            else if (!run || !ps_en || last) div_q <= '0;
            else                             div_q <= div_q + 1'b1;
         end

         assign tick = run && (!ps_en || last);
      end else begin : g_direct
         assign tick = run;
      end
   endgenerate
endmodule

// File: rtl/tpwm_counter.sv
module tpwm_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wd,
   input  logic [CNT_W-1:0] load,
   input  logic [CNT_W-1:0] match,
   input  logic             arl,
   input  logic             cmp_en,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf_ev,
   output logic             cmp_ev
);
   localparam logic [CNT_W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (cnt_we) cnt <= cnt_wd;
      else if (tick)   cnt <= (cnt == TOP) ? (arl ? load : '0) : cnt + 1'b1;
   end

   assign ovf_ev = tick && (cnt == TOP);
   assign cmp_ev = tick && cmp_en && (cnt == match);
endmodule

// File: rtl/tpwm_toggle.sv
module tpwm_toggle
   import tpwm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ovf_ev,
   input  logic       cmp_ev,
   input  tpwm_mode_e mode,
   input  logic       inv,
   input  logic       clr,
   output logic       pwm_out
);
   logic tgl_q;
   logic flip;

   always_comb begin
      case (mode)
         M_OFF:   flip = 1'b0;
         M_OVF:   flip = ovf_ev;
         default: flip = ovf_ev | cmp_ev;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tgl_q <= 1'b0;
      else if (clr)  tgl_q <= 1'b0;
      else if (flip) tgl_q <= ~tgl_q;
   end

   assign pwm_out = tgl_q ^ inv;
endmodule

// File: rtl/tpwm_timer.sv
module tpwm_timer
   import tpwm_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned PS_W   = 3,
   parameter bit          HAS_PS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic             pwm_out
);
   localparam int unsigned INV_B    = PS_LSB + PS_W;
   localparam int unsigned MODE_LSB = INV_B + 1;
   localparam int unsigned CTRL_W   = MODE_LSB + 2;

   if (CNT_W < CTRL_W) begin : g_bad_width
      $error("tpwm_timer: CNT_W too narrow for the control word");
   end
   if (PS_W < 1 || PS_W > 4) begin : g_bad_ps
      $error("tpwm_timer: PS_W must be 1..4");
   end

   logic             run_q, arl_q, cmp_en_q, ps_en_q, inv_q;
   logic [PS_W-1:0]  ps_q;
   tpwm_mode_e       mode_q;
   logic [CNT_W-1:0] load_q, match_q, cnt_q;
   logic             tick, ovf_ev, cmp_ev;
   logic             wr_ctrl, wr_load, wr_match, cnt_we, clr;
   logic             stopped;
   tpwm_mode_e       new_mode;

   assign stopped  = !run_q;
   assign wr_ctrl  = wr_en && (tpwm_addr_e'(wr_addr) == A_CTRL);
   assign wr_load  = wr_en && (tpwm_addr_e'(wr_addr) == A_LOAD)  && stopped;
   assign wr_match = wr_en && (tpwm_addr_e'(wr_addr) == A_MATCH) && stopped;
   assign cnt_we   = wr_en && (tpwm_addr_e'(wr_addr) == A_COUNT) && stopped;
   assign new_mode = tpwm_mode_e'(wr_data[MODE_LSB +: 2]);
   assign clr      = cnt_we || (wr_ctrl && stopped && (new_mode != mode_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         arl_q    <= 1'b0;
         cmp_en_q <= 1'b0;
         ps_en_q  <= 1'b0;
         ps_q     <= '0;
         inv_q    <= 1'b0;
         mode_q   <= M_OFF;
         load_q   <= '0;
         match_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            run_q <= wr_data[RUN_B];
            if (stopped) begin
               arl_q    <= wr_data[ARL_B];
               cmp_en_q <= wr_data[CMP_B];
               ps_en_q  <= wr_data[PSEN_B];
               ps_q     <= wr_data[PS_LSB +: PS_W];
               inv_q    <= wr_data[INV_B];
               mode_q   <= new_mode;
            end
         end
         if (wr_load)  load_q  <= wr_data;
         if (wr_match) match_q <= wr_data;
      end
   end

   tpwm_prescaler #(.PS_W(PS_W), .HAS_PS(HAS_PS)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run_q), .ps_en(ps_en_q), .ps(ps_q), .tick(tick)
   );

   tpwm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we), .cnt_wd(wr_data),
      .load(load_q), .match(match_q), .arl(arl_q), .cmp_en(cmp_en_q),
      .cnt(cnt_q), .ovf_ev(ovf_ev), .cmp_ev(cmp_ev)
   );

   tpwm_toggle u_tgl (
      .clk(clk), .rst_n(rst_n), .ovf_ev(ovf_ev), .cmp_ev(cmp_ev),
      .mode(mode_q), .inv(inv_q), .clr(clr), .pwm_out(pwm_out)
   );
endmodule

// File: rtl/tpwm_timer_chk.sv
module tpwm_timer_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             run,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] load,
   input logic [CNT_W-1:0] match,
   input logic             arl,
   input logic             ps_en,
   input logic [1:0]       mode,
   input logic             pwm_out
);
   localparam logic [CNT_W-1:0] TOP = '1;

   AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == TOP && arl) |=> (cnt == $past(load))); // R2
   AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == TOP && !arl) |=> (cnt == '0)); // R2
   AST_OVF_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == TOP && mode != 2'd0) |=> (pwm_out != $past(pwm_out))); // R10
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (load == $past(load) && match == $past(match))); // R8
   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_en) |=> $stable(pwm_out)); // R11
   AST_OFF_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && !wr_en) |=> $stable(pwm_out)); // R9
   AST_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick); // R7
   AST_TICK_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ps_en) |-> tick); // R7
endmodule

bind tpwm_timer tpwm_timer_chk #(.CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .run(run_q), .tick(tick),
   .cnt(cnt_q), .load(load_q), .match(match_q), .arl(arl_q), .ps_en(ps_en_q),
   .mode(mode_q), .pwm_out(pwm_out)
);

// File: tb/tpwm_timer_tb_top.sv
module tpwm_timer_tb_top;
   localparam int          CLK_PERIOD = 10;
   localparam int          WD_CYCLES  = 150000;
   localparam logic [31:0] MAX        = 32'hFFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [31:0] wr_data = '0;
   logic        pwm_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   bit busy = 1'b0;

   typedef struct { int hi; int per; string tag; } item_t;
   item_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   tpwm_timer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_out(pwm_out)
   );

   task automatic chk(input string r, input int act, input int expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", r, act, expv);
      end
   endtask

   function automatic logic [31:0] cw(input bit run, arl, cmp, psen,
                                      input int ps, input bit inv, input int mode);
      return {22'd0, 2'(mode), inv, 3'(ps), psen, cmp, arl, run};
   endfunction

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // halt, program, preset counter, leave halted
   task automatic cfg(input logic [31:0] ld, input logic [31:0] mt, input logic [31:0] c);
      wr(2'd0, 32'd0);
      wr(2'd0, c & ~32'd1);
      wr(2'd1, ld);
      wr(2'd2, mt);
      wr(2'd3, MAX - 1);
   endtask

   task automatic measure(input int hi, input int per, input string tag);
      item_t it;
      it.hi = hi; it.per = per; it.tag = tag;
      exp_q.push_back(it);
      wait (exp_q.size() == 0);
      wait (!busy);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         item_t it;
         int hi, lo;
         wait (exp_q.size() != 0);
         busy = 1'b1;
         it = exp_q.pop_front();
         do @(negedge clk); while (pwm_out !== 1'b0);
         do @(negedge clk); while (pwm_out !== 1'b1);
         hi = 0;
         while (pwm_out === 1'b1) begin hi++; @(negedge clk); end
         lo = 0;
         while (pwm_out === 1'b0) begin lo++; @(negedge clk); end
         chk({it.tag, " high"}, hi, it.hi);
         chk({it.tag, " period"}, hi + lo, it.per);
         busy = 1'b0;
      end
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic run_until_high();
      do @(negedge clk); while (pwm_out !== 1'b0);
      do @(negedge clk); while (pwm_out !== 1'b1);
   endtask

   initial begin
      int flat;
      logic [31:0] ca;
      repeat (3) @(negedge clk);
      chk("R1 reset level", pwm_out, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 idle level", pwm_out, 0);

      ca = cw(0, 1, 1, 0, 0, 0, 2);

      // R5: first event edge
      cfg(MAX - 9, MAX - 6, ca);
      wr(2'd0, ca | 1);
      chk("R5 edge+0", pwm_out, 0);
      @(negedge clk); chk("R5 tick1", pwm_out, 0);
      @(negedge clk); chk("R5 tick2", pwm_out, 1);

      // R3 R4 several load/match pairs
      measure(4, 10, "R3 R4 pair A");
      cfg(MAX - 19, MAX - 19, ca); wr(2'd0, ca | 1);
      measure(1, 20, "R3 R4 pair B");
      cfg(MAX - 15, MAX - 3, ca); wr(2'd0, ca | 1);
      measure(13, 16, "R3 R4 pair C");

      // R8: writes while running ignored
      cfg(MAX - 9, MAX - 6, ca); wr(2'd0, ca | 1);
      wr(2'd1, MAX - 29);
      wr(2'd2, MAX - 1);
      wr(2'd3, 32'd5);
      wr(2'd0, cw(1, 1, 1, 0, 0, 1, 1));
      measure(4, 10, "R8 running writes");

      // R6: inversion, default high
      cfg(MAX - 9, MAX - 6, cw(0, 1, 1, 0, 0, 1, 2));
      chk("R6 default level", pwm_out, 1);
      wr(2'd0, cw(1, 1, 1, 0, 0, 1, 2));
      measure(6, 10, "R6 inverted");

      // R7: prescaler ratios 2 and 4
      cfg(MAX - 9, MAX - 6, cw(0, 1, 1, 1, 0, 0, 2)); wr(2'd0, cw(1, 1, 1, 1, 0, 0, 2));
      measure(8, 20, "R7 ps0");
      cfg(MAX - 9, MAX - 6, cw(0, 1, 1, 1, 1, 0, 2)); wr(2'd0, cw(1, 1, 1, 1, 1, 0, 2));
      measure(16, 40, "R7 ps1");

      // R9: compare disabled, overflow-only mode, off mode
      cfg(MAX - 9, MAX - 6, cw(0, 1, 0, 0, 0, 0, 2)); wr(2'd0, cw(1, 1, 0, 0, 0, 0, 2));
      measure(10, 20, "R9 cmp disabled");
      cfg(MAX - 9, MAX - 6, cw(0, 1, 1, 0, 0, 0, 1)); wr(2'd0, cw(1, 1, 1, 0, 0, 0, 1));
      measure(10, 20, "R9 overflow mode");
      cfg(MAX - 9, MAX - 6, cw(0, 1, 1, 0, 0, 0, 0)); wr(2'd0, cw(1, 1, 1, 0, 0, 0, 0));
      flat = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (pwm_out !== 1'b0) flat++; end
      chk("R9 off mode", flat, 0);

      // R10: coincident overflow and match
      cfg(MAX - 9, MAX, ca); wr(2'd0, ca | 1);
      measure(10, 20, "R10 coincident");

      // R2: no auto-reload wraps to zero, then matches at 1
      cfg(MAX - 9, 32'd1, cw(0, 0, 1, 0, 0, 0, 2));
      wr(2'd0, cw(1, 0, 1, 0, 0, 0, 2));
      @(negedge clk); @(negedge clk); chk("R2 wrap rise", pwm_out, 1);
      @(negedge clk); chk("R2 at zero", pwm_out, 1);
      @(negedge clk); chk("R2 match at one", pwm_out, 0);
      // with reload, same match is never reached
      cfg(MAX - 9, 32'd1, ca); wr(2'd0, ca | 1);
      repeat (4) @(negedge clk); chk("R2 reload keeps high", pwm_out, 1);

      // R11 R12: hold while halted, clear by count write
      cfg(MAX - 9, MAX - 6, ca); wr(2'd0, ca | 1);
      run_until_high();
      wr(2'd0, ca);
      repeat (20) @(negedge clk);
      chk("R11 hold high", pwm_out, 1);
      wr(2'd3, MAX - 1);
      chk("R12 count write", pwm_out, 0);

      // R12: mode change clears, same-mode write does not
      wr(2'd0, ca | 1);
      run_until_high();
      wr(2'd0, ca);
      wr(2'd0, ca);
      chk("R12 same mode keeps", pwm_out, 1);
      wr(2'd0, cw(0, 1, 1, 0, 0, 0, 1));
      chk("R12 mode change", pwm_out, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule